// File: doc/BRIEF.md
# Nibble-Addressed Double-Buffered DAC Register

This block is the digital front end of a 12-bit parallel-input converter. A microprocessor-style bus writes the code through an 8-bit data port in pieces: a 4-bit nibble into the low, middle or high position, or one byte covering the low and middle nibbles at once. Those pieces collect in an input latch. A separate active-low load strobe moves the whole latch into the output code register. The converter core reads that register. Because of the two stages, a new code can be assembled piece by piece without the output ever showing a partly written value.

All bus strobes are asynchronous to the block clock. Each one passes through a two-flop synchronizer. A write commits when the combined chip-select-and-write strobe is released (its rising edge). It uses the address and data that were present while the strobe was active. An active-low clear forces the output register to zero and wins over load. Clear leaves the input latch alone.

Top module: `nibble_dac_front`

## Requirements
- R1: After reset the output code is 0x000 and every input-latch nibble is zero, so a load with no prior write leaves the code at 0x000.
- R2: A write happens only while cs_n and wr_n are both low. It commits when that combined strobe is released. With either strobe high, the input latch does not change.
- R3: sel = 2'b10 (sel[1]=1, sel[0]=0) writes bus bits 3:0 into input-latch bits 3:0 and leaves the other nibbles unchanged.
- R4: sel = 2'b01 writes bus bits 7:4 into input-latch bits 7:4 and leaves the other nibbles unchanged.
- R5: sel = 2'b11 writes bus bits 3:0 into input-latch bits 11:8 and leaves the other nibbles unchanged.
- R6: sel = 2'b00 writes bus bits 7:0 into input-latch bits 7:0 in one write and leaves bits 11:8 unchanged.
- R7: While ld_n and clr_n are high, the output code holds its value, including when the input latch is written.
- R8: Driving ld_n low copies the whole input latch to the output code, whatever the levels of cs_n and wr_n.
- R9: While ld_n stays low, the output code follows each input-latch update. After ld_n goes high, the code keeps its last value.
- R10: Driving clr_n low forces the output code to 0x000. This holds even when ld_n is low at the same time.
- R11: Clear does not alter the input latch. A load after the clear is released restores the latch contents to the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| sel | input | 2 | Part select for the write (see R3 to R6) |
| data | input | 8 | Write data bus |
| ld_n | input | 1 | Load input latch into output code, active low, asynchronous |
| clr_n | input | 1 | Clear output code, active low, asynchronous |
| code | output | 12 | Output code for the converter core |

## Verification
The bound checker watches, on every cycle, the relations between the synchronized strobes and the two registers. Clear forces zero, and clear wins over load. An idle output holds. A load copies the latch. Without a commit the latch stays stable. A high-nibble commit lands in bits 11:8. The bench scenarios show the behaviour seen from the pins: the value each address code builds, gated writes that leave no trace, transparency and hold around a held load, and the latch surviving a clear. These are all visible only by reading the output code back after a load.

// File: rtl/dac_front_pkg.sv
// Package: shared widths, select codes and decode helpers for the
// nibble-addressed DAC front end. Assumes a 4-bit nibble and an 8-bit bus.
package dac_front_pkg;

    localparam int NIB_W   = 4;
    localparam int NIBBLES = 3;
    localparam int CODE_W  = NIB_W * NIBBLES;
    localparam int BUS_W   = 2 * NIB_W;
    localparam int SEL_W   = 2;

    // Part-select codes; {sel[1], sel[0]}
    typedef enum logic [SEL_W-1:0] {
        SEL_BYTE = 2'b00,   // low + middle from bus[7:0]
        SEL_MID  = 2'b01,   // middle from bus[7:4]
        SEL_LOW  = 2'b10,   // low from bus[3:0]
        SEL_HIGH = 2'b11    // high from bus[3:0]
    } part_sel_e;

    // Which nibbles a select code writes, one bit per nibble
    function automatic logic [NIBBLES-1:0] nibble_mask(input part_sel_e s);
        logic [NIBBLES-1:0] m;
        m = '0;
        unique case (s)
            SEL_BYTE: begin m[0] = 1'b1; m[1] = 1'b1; end
            SEL_MID:  m[1] = 1'b1;
            SEL_LOW:  m[0] = 1'b1;
            SEL_HIGH: m[2] = 1'b1;
        endcase
        return m;
    endfunction

    // Which bus half feeds a nibble: 0 = bits 3:0, 1 = bits 7:4
    function automatic logic nibble_src_upper(input int idx, input part_sel_e s);
        logic up;
        up = 1'b0;
        if (idx == 1) begin
            up = 1'b1;
        end
        if (s == SEL_HIGH) begin
            up = 1'b0;
        end
        return up;
    endfunction

endpackage

// File: rtl/dac_strobe_sync.sv
// Module: multi-bit synchronizer for independent asynchronous strobes.
// Each bit gets its own chain of STAGES flops. Reset loads IDLE_VAL so the
// strobes read as inactive. Assumes each bit is a slow level, not a bus.
module dac_strobe_sync #(
    parameter int              WIDTH    = 4,
    parameter int              STAGES   = 2,
    parameter logic [WIDTH-1:0] IDLE_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    localparam int LAST = STAGES - 1;

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain;

            // Shift the raw level through the synchronizer chain
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain <= {STAGES{IDLE_VAL[b]}};
                end else begin
                    chain <= {chain[STAGES-2:0], async_in[b]};
                end
            end

            assign sync_out[b] = chain[LAST];
        end
    endgenerate

endmodule

// File: rtl/dac_write_capture.sv
// Module: turns the synchronized chip-select and write strobes into a
// one-cycle commit pulse. The pulse fires when the combined active-low
// strobe is released. Select and data are captured on every cycle the
// strobe is active, so the commit uses the last values seen while active.
// Assumes the bus is stable while the synchronized strobe is active.
module dac_write_capture
    import dac_front_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_s,
    input  logic             wr_s,
    input  logic [SEL_W-1:0] sel_raw,
    input  logic [BUS_W-1:0] data_raw,
    output logic             commit,
    output part_sel_e        sel_q,
    output logic [BUS_W-1:0] data_q
);

    logic strobe_act;
    logic strobe_act_q;

    // Write is active when both active-low strobes are low
    always_comb begin
        strobe_act = ~cs_s & ~wr_s;
    end

    // Remember the previous strobe state for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_act_q <= 1'b0;
        end else begin
            strobe_act_q <= strobe_act;
        end
    end

    // Track select and data while the write strobe is active
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= SEL_BYTE;
            data_q <= '0;
        end else if (strobe_act) begin
            sel_q  <= part_sel_e'(sel_raw);
            data_q <= data_raw;
        end
    end

    // Release of the combined strobe commits the captured write
    always_comb begin
        commit = strobe_act_q & ~strobe_act;
    end

endmodule

// File: rtl/dac_input_latch.sv
// Module: first buffer stage. It holds NIBBLES nibbles and updates the ones
// chosen by the select code on a commit pulse. Each nibble takes its
// source half of the bus from the package decode. Assumes one commit per
// write.
module dac_input_latch
    import dac_front_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  part_sel_e         sel_q,
    input  logic [BUS_W-1:0]  data_q,
    output logic [CODE_W-1:0] latch_q
);

    logic [NIBBLES-1:0] wr_mask;

    // Decode the select code into per-nibble write enables
    always_comb begin
        wr_mask = commit ? nibble_mask(sel_q) : '0;
    end

    generate
        for (genvar n = 0; n < NIBBLES; n++) begin : g_nib
            logic [NIB_W-1:0] src;

            // Pick the bus half that feeds this nibble
            always_comb begin
                if (nibble_src_upper(n, sel_q)) begin
                    src = data_q[BUS_W-1:NIB_W];
                end else begin
                    src = data_q[NIB_W-1:0];
                end
            end

            // Store the nibble when its enable is set
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    latch_q[n*NIB_W +: NIB_W] <= '0;
                end else if (wr_mask[n]) begin
                    latch_q[n*NIB_W +: NIB_W] <= src;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/dac_code_reg.sv
// Module: second buffer stage, the output code register. Clear wins over
// load. While load is active the register takes the latch every cycle
// (transparent). Otherwise it holds. Assumes synchronized strobes.
module dac_code_reg
    import dac_front_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_s,
    input  logic              clr_s,
    input  logic [CODE_W-1:0] latch_q,
    output logic [CODE_W-1:0] code_q
);

    // Update the output code with clear over load over hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (!clr_s) begin
            code_q <= '0;
        end else if (!ld_s) begin
            code_q <= latch_q;
        end
    end

endmodule

// File: rtl/nibble_dac_front.sv
// Module: top of the double-buffered DAC front end. It synchronizes the
// four asynchronous strobes, builds commit pulses from chip select and
// write, assembles the code in the input latch and moves it to the output
// register on load. Assumes bus data stable around each write strobe.
module nibble_dac_front
    import dac_front_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic [1:0]        sel,
    input  logic [7:0]        data,
    input  logic              ld_n,
    input  logic              clr_n,
    output logic [11:0]       code
);

    localparam int N_STROBES = 4;

    logic [N_STROBES-1:0] strobes_raw;
    logic [N_STROBES-1:0] strobes_s;
    logic                 cs_s;
    logic                 wr_s;
    logic                 ld_s;
    logic                 clr_s;
    logic                 commit;
    part_sel_e            sel_q;
    logic [BUS_W-1:0]     data_q;
    logic [CODE_W-1:0]    latch_q;
    logic [CODE_W-1:0]    code_q;

    // Gather the strobes into one vector for the synchronizer
    always_comb begin
        strobes_raw = {clr_n, ld_n, wr_n, cs_n};
    end

    dac_strobe_sync #(
        .WIDTH    (N_STROBES),
        .STAGES   (SYNC_STAGES),
        .IDLE_VAL ({N_STROBES{1'b1}})
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (strobes_raw),
        .sync_out (strobes_s)
    );

    // Split the synchronized vector into named strobes
    always_comb begin
        cs_s  = strobes_s[0];
        wr_s  = strobes_s[1];
        ld_s  = strobes_s[2];
        clr_s = strobes_s[3];
    end

    dac_write_capture u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_s     (cs_s),
        .wr_s     (wr_s),
        .sel_raw  (sel),
        .data_raw (data),
        .commit   (commit),
        .sel_q    (sel_q),
        .data_q   (data_q)
    );

    dac_input_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit),
        .sel_q   (sel_q),
        .data_q  (data_q),
        .latch_q (latch_q)
    );

    dac_code_reg u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_s    (ld_s),
        .clr_s   (clr_s),
        .latch_q (latch_q),
        .code_q  (code_q)
    );

    assign code = code_q;

endmodule

// File: rtl/nibble_dac_front_chk.sv
// Checker: cycle-by-cycle properties between the synchronized strobes,
// the input latch and the output code. Attached to the top by bind.
module nibble_dac_front_chk
    import dac_front_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ld_s,
    input logic              clr_s,
    input logic              commit,
    input part_sel_e         sel_q,
    input logic [BUS_W-1:0]  data_q,
    input logic [CODE_W-1:0] latch_q,
    input logic [CODE_W-1:0] code
);

    assert_clear_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_s |=> code == '0);

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_s && clr_s) |=> $stable(code));

    assert_load_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_s && clr_s) |=> code == $past(latch_q));

    assert_latch_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(latch_q));

    assert_high_nibble_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && sel_q == SEL_HIGH) |=>
            (latch_q[11:8] == $past(data_q[3:0]) && latch_q[7:0] == $past(latch_q[7:0])));

endmodule

bind nibble_dac_front nibble_dac_front_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_s    (ld_s),
    .clr_s   (clr_s),
    .commit  (commit),
    .sel_q   (sel_q),
    .data_q  (data_q),
    .latch_q (latch_q),
    .code    (code)
);

// File: tb/sim_nibble_dac_front.sv
// Directed bench for nibble_dac_front: one task per scenario.
module sim_nibble_dac_front;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [1:0]  sel = 2'b00;
    logic [7:0]  data = 8'h00;
    logic        ld_n = 1'b1;
    logic        clr_n = 1'b1;
    logic [11:0] code;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    nibble_dac_front u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .sel(sel),
        .data(data), .ld_n(ld_n), .clr_n(clr_n), .code(code)
    );

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: code actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Bus write; gate selects which strobe stays high (0 none, 1 cs, 2 wr)
    task automatic bus_write(input logic [1:0] s, input logic [7:0] d, input int gate);
        @(negedge clk);
        sel = s; data = d;
        cs_n = (gate == 1); wr_n = (gate == 2);
        idle(4);
        cs_n = 1'b1; wr_n = 1'b1;
        idle(6);
    endtask

    task automatic pulse_load();
        @(negedge clk); ld_n = 1'b0;
        idle(4);
        ld_n = 1'b1;
        idle(6);
    endtask

    task automatic t_reset();
        check("R1 reset code", code, 12'h000);
        pulse_load();
        check("R1 latch zero after reset", code, 12'h000);
    endtask

    task automatic t_nibbles();
        bus_write(2'b10, 8'hF5, 0);
        bus_write(2'b01, 8'hAA, 0);
        bus_write(2'b11, 8'h3C, 0);
        check("R7 code held during writes", code, 12'h000);
        pulse_load();
        check("R3 R4 R5 R8 nibble build", code, 12'hCA5);
    endtask

    task automatic t_byte();
        bus_write(2'b00, 8'h3E, 0);
        check("R7 code held after byte write", code, 12'hCA5);
        pulse_load();
        check("R6 byte write", code, 12'hC3E);
        bus_write(2'b01, 8'h96, 0);
        pulse_load();
        check("R4 middle from upper bus half", code, 12'hC9E);
    endtask

    task automatic t_gating();
        bus_write(2'b11, 8'h01, 1);
        bus_write(2'b10, 8'h00, 2);
        pulse_load();
        check("R2 gated writes ignored", code, 12'hC9E);
        @(negedge clk); cs_n = 1'b0; wr_n = 1'b1;
        bus_write(2'b00, 8'h00, 2);
        @(negedge clk); ld_n = 1'b0;
        idle(5);
        check("R8 load independent of cs", code, 12'hC9E);
        ld_n = 1'b1; cs_n = 1'b1;
        idle(4);
    endtask

    task automatic t_transparent();
        @(negedge clk); ld_n = 1'b0;
        idle(5);
        bus_write(2'b10, 8'h07, 0);
        check("R9 transparent follow", code, 12'hC97);
        bus_write(2'b11, 8'h02, 0);
        check("R9 transparent follow high", code, 12'h297);
        ld_n = 1'b1;
        idle(5);
        bus_write(2'b11, 8'h01, 0);
        check("R9 hold after release", code, 12'h297);
        pulse_load();
        check("R8 load after hold", code, 12'h197);
    endtask

    task automatic t_clear();
        @(negedge clk); clr_n = 1'b0;
        idle(5);
        check("R10 clear zero", code, 12'h000);
        ld_n = 1'b0;
        idle(5);
        check("R10 clear over load", code, 12'h000);
        ld_n = 1'b1;
        idle(5);
        clr_n = 1'b1;
        idle(5);
        check("R10 code stays zero after clear", code, 12'h000);
        pulse_load();
        check("R11 latch survives clear", code, 12'h197);
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(6);
        t_reset();
        t_nibbles();
        t_byte();
        t_gating();
        t_transparent();
        t_clear();
        report();
    end

endmodule